// File: doc/BRIEF.md
# Byte-Lane Static Memory Emulator

This block is a clocked stand-in for a 16-bit asynchronous static memory made of two independent 8-bit lanes. It takes the usual active-low controls of such a part (chip select, write strobe, output gate and one select per byte) together with an address and a write word. It returns the addressed word on a read-data bus and a two-bit lane-drive vector that says which byte lanes would be driving a shared tri-state bus. No tri-state nets are used, so a surrounding design or bench can see bus ownership directly.

Writes are committed on the rising clock edge on which the write condition is sampled. Reads are combinational from the currently addressed word, in the way an asynchronous part returns data without a strobe. The pins form a plain strobe interface. No word stream passes through the block, so there is no valid/ready handshake and no back-pressure: each sampled control combination takes effect at once. The depth is set by the address-width parameter. Its default is small so that simulation stays quick. Memory contents clear to zero on reset.

Top module: `sram_bytelane_emu`

## Requirements
- R1: While `ce_n` is 1, `lane_drive` is 2'b00 and `rdata` is zero, whatever the other controls are, and no write happens.
- R2: With `ce_n`=0 and `we_n`=0 and at least one byte select low, the selected lanes of `wdata` are stored at `addr` on that rising clock edge, whatever the value of `oe_n`.
- R3: During a write, `lb_n`=0 enables bits 7:0 and `ub_n`=0 enables bits 15:8. A lane whose select is 1 keeps its previous contents.
- R4: While `ce_n`=0 and `we_n`=0, `lane_drive` is 2'b00 and `rdata` is zero.
- R5: With `ce_n`=0, `we_n`=1 and `oe_n`=0, bit 0 of `lane_drive` equals the inverse of `lb_n` and bit 1 equals the inverse of `ub_n`. Each driving lane shows the stored byte of the addressed word.
- R6: With `ce_n`=0, `we_n`=1 and `oe_n`=1, `lane_drive` is 2'b00.
- R7: With `lb_n`=1 and `ub_n`=1, `lane_drive` is 2'b00 even when `ce_n` and `oe_n` are 0.
- R8: After reset every word reads as 16'h0000.
- R9: The bits of any lane whose `lane_drive` bit is 0 read as zero on `rdata`.
- R10: A cycle with `we_n`=0 but `ce_n`=1, or with both byte selects at 1, leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears the memory |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| lb_n | input | 1 | Active-low select for bits 7:0 |
| ub_n | input | 1 | Active-low select for bits 15:8 |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Read word; lanes not driving read as zero |
| lane_drive | output | 2 | Bit 0: low lane drives; bit 1: high lane drives |

## Verification
The checker assumes that every control pin and the address are known values once reset has been released, and that they change only away from the rising clock edge, so each edge sees one stable mode. Its output properties are sampled at the rising edge, where the combinational read path has settled from inputs set during the previous low phase. The bench drives every input at the falling edge and always supplies definite levels, including on the controls that should have no effect in a given mode. Because of this, the properties never meet an unknown or changing control.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  localparam int NUM_LANES = 2;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_OUT_OFF = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

  typedef struct packed {
    logic [NUM_LANES-1:0] wr;
    logic [NUM_LANES-1:0] rd;
  } lane_ctl_t;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_emu_pkg::*;
(
  input  logic                 ce_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic [NUM_LANES-1:0] sel_n,
  output sram_mode_e           mode,
  output lane_ctl_t            ctl
);
  logic [NUM_LANES-1:0] sel;
  assign sel = ~sel_n;

  // Priority: chip select, then byte selects, then write strobe, then output gate.
  always_comb begin
    if (ce_n)            mode = MODE_IDLE;
    else if (sel == '0)  mode = MODE_OUT_OFF;
    else if (!we_n)      mode = MODE_WRITE;
    else if (oe_n)       mode = MODE_OUT_OFF;
    else                 mode = MODE_READ;
  end

  always_comb begin
    ctl = '0;
    unique case (mode)
      MODE_WRITE: ctl.wr = sel;
      MODE_READ:  ctl.rd = sel;
      default:    ctl    = '0;
    endcase
  end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/sram_read_gate.sv
module sram_read_gate
  import sram_emu_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [NUM_LANES-1:0]        lane_rd,
  input  logic [NUM_LANES*LANE_W-1:0] raw,
  output logic [NUM_LANES*LANE_W-1:0] gated,
  output logic [NUM_LANES-1:0]        drive
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_gate
    assign gated[g*LANE_W +: LANE_W] = lane_rd[g] ? raw[g*LANE_W +: LANE_W] : '0;
    assign drive[g] = lane_rd[g];
  end
endmodule

// File: rtl/sram_bytelane_emu.sv
module sram_bytelane_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce_n,
  input  logic                        we_n,
  input  logic                        oe_n,
  input  logic                        lb_n,
  input  logic                        ub_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_LANES*LANE_W-1:0] wdata,
  output logic [NUM_LANES*LANE_W-1:0] rdata,
  output logic [NUM_LANES-1:0]        lane_drive
);
  localparam int WORD_W = NUM_LANES * LANE_W;

  sram_mode_e  mode;
  lane_ctl_t   ctl;
  logic [WORD_W-1:0] raw_word;

  sram_mode_decode u_dec (
    .ce_n  (ce_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .sel_n ({ub_n, lb_n}),
    .mode  (mode),
    .ctl   (ctl)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sram_byte_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (ctl.wr[g]),
      .addr  (addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (raw_word[g*LANE_W +: LANE_W])
    );
  end

  sram_read_gate #(.LANE_W(LANE_W)) u_gate (
    .lane_rd (ctl.rd),
    .raw     (raw_word),
    .gated   (rdata),
    .drive   (lane_drive)
  );
endmodule

// File: rtl/sram_bytelane_emu_chk.sv
module sram_bytelane_emu_chk #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce_n,
  input logic                we_n,
  input logic                oe_n,
  input logic                lb_n,
  input logic                ub_n,
  input logic [2*LANE_W-1:0] rdata,
  input logic [1:0]          lane_drive
);
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (lane_drive == 2'b00 && rdata == '0));

  a_r4_write_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> (lane_drive == 2'b00));

  a_r5_lane_map: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && !oe_n) |-> (lane_drive == {~ub_n, ~lb_n}));

  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |-> (lane_drive == 2'b00));

  a_r7_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |-> (lane_drive == 2'b00));

  a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_drive[0] |-> (rdata[LANE_W-1:0] == '0));

  a_r9_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_drive[1] |-> (rdata[2*LANE_W-1:LANE_W] == '0));
endmodule

bind sram_bytelane_emu sram_bytelane_emu_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .lb_n       (lb_n),
  .ub_n       (ub_n),
  .rdata      (rdata),
  .lane_drive (lane_drive)
);

// File: tb/sram_bytelane_emu_bench.sv
`timescale 1ns/1ps
module sram_bytelane_emu_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  lane_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mdl [DEPTH];
  logic [15:0] q_rd [$];
  logic [1:0]  q_dr [$];
  string       q_tag [$];

  always #10 clk = ~clk;

  sram_bytelane_emu #(.ADDR_W(AW), .LANE_W(8)) u_sram_bytelane_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_drive(lane_drive)
  );

  // Driver: one bus cycle per call, expectation pushed to the scoreboard.
  task automatic apply(input logic c, input logic w, input logic o, input logic l,
                       input logic u, input logic [AW-1:0] a, input logic [15:0] d,
                       input string tag);
    logic [1:0]  edr;
    logic [15:0] erd;
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; wdata = d;
    edr = 2'b00;
    if (!c && w && !o) edr = {~u, ~l};
    erd = {edr[1] ? mdl[a][15:8] : 8'h00, edr[0] ? mdl[a][7:0] : 8'h00};
    q_rd.push_back(erd);
    q_dr.push_back(edr);
    q_tag.push_back(tag);
    if (!c && !w) begin
      if (!l) mdl[a][7:0]  = d[7:0];
      if (!u) mdl[a][15:8] = d[15:8];
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 16'h0000, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input string tag);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, d, tag);
  endtask

  // Monitor: samples mid low phase, after inputs settle and before the commit edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q_rd.size() != 0) begin
        logic [15:0] erd;
        logic [1:0]  edr;
        string tag;
        erd = q_rd.pop_front();
        edr = q_dr.pop_front();
        tag = q_tag.pop_front();
        checks++;
        if (rdata !== erd || lane_drive !== edr) begin
          failures++;
          $display("FAIL %s: rdata=%h drive=%b expected rdata=%h drive=%b",
                   tag, rdata, lane_drive, erd, edr);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1 while in reset: deselected, nothing on the bus
    @(negedge clk); #5;
    checks++;
    if (rdata !== 16'h0 || lane_drive !== 2'b00) begin
      failures++;
      $display("FAIL R1 reset: rdata=%h drive=%b expected rdata=0000 drive=00", rdata, lane_drive);
    end
    rst_n = 1'b1;

    rd(6'd5, "R8 cleared word");
    rd(6'd63, "R8 cleared top word");
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, 16'hA5C3, "R4 write with oe low");
    rd(6'd3, "R2 word readback");
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd3, 16'h1177, "R4 low-lane write");
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd3, 16'h9900, "R4 high-lane write");
    rd(6'd3, "R3 merged lanes");
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd3, 16'h0, "R5 R9 low lane only");
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd3, 16'h0, "R5 R9 high lane only");
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 16'h0, "R6 gate high");
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd3, 16'h0, "R7 no byte selected");
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, 16'hFFFF, "R1 deselected write");
    rd(6'd3, "R10 after deselected write");
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd3, 16'hFFFF, "R7 write without bytes");
    rd(6'd3, "R10 after byteless write");
    wr(6'd0, 16'h0F0F, "R2 bottom address");
    wr(6'd63, 16'hF0F0, "R2 top address");
    rd(6'd0, "R2 bottom readback");
    rd(6'd63, "R2 top readback");
    for (int i = 0; i < DEPTH; i++) begin
      apply(1'b0, 1'b0, i[0], i[1], ~i[1] & i[2], i[AW-1:0],
            16'h1000 * i[3:0] + 16'h0101 * i[7:0], "R3 sweep write");
    end
    for (int i = 0; i < DEPTH; i++) rd(i[AW-1:0], "R3 sweep readback");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule